// File: doc/BRIEF.md
# Paging Address Translator with Associative Lookup Buffer

The block turns a virtual address into a physical address. The virtual address splits into two parts. The upper `VPN_W` bits are the page number and the lower `OFF_W` bits are the offset inside the page. Page frames are aligned to the page size, so the physical address is the frame number with the offset appended below it. A small, fully associative buffer holds recently used translations. The page number is compared against every valid slot at the same time, and a hit answers one cycle after the request is accepted, with no memory traffic.

On a miss, a small walker reads one page table entry over a simple memory read port. The entry address is the table base input plus the page number. The most significant bit of the entry is the resident flag. When the flag is set, the low `PFN_W` bits give the frame, the walker answers with the translation, and it writes the translation into the slot chosen by a round-robin pointer. When the flag is clear, the rest of the entry is a backing-store location. The walker then reports a page fault and leaves the buffer unchanged. A flush input clears every slot.

The walker has three states:
- `WK_IDLE`: accepts requests and looks them up.
- `WK_ISSUE`: drives the memory request for one cycle.
- `WK_WAIT`: holds until the memory answers.

The transitions are:
- `WK_IDLE`→`WK_ISSUE` on an accepted miss.
- `WK_ISSUE`→`WK_WAIT` always.
- `WK_WAIT`→`WK_IDLE` on the memory response.

A hit stays in `WK_IDLE`.

Top module: `page_xlate_top`

## Requirements
- R1: The response address `rsp_paddr` equals the frame number in bits `[PA_W-1:OFF_W]` with the request offset unchanged in bits `[OFF_W-1:0]`.
- R2: A request whose page number matches a valid buffer slot produces `rsp_valid` with `rsp_hit`=1 on the cycle after acceptance, and issues no memory read.
- R3: A miss issues exactly one memory read, whose address is `table_base` plus the zero-extended page number, modulo 2^`MADDR_W`.
- R4: When bit `PTE_W-1` (resident) of the returned entry is 1, the response carries the frame from entry bits `[PFN_W-1:0]`, with `rsp_hit`=0 and `rsp_fault`=0. The translation is then installed, so a repeat request hits.
- R5: When the resident bit is 0, the response has `rsp_fault`=1 and `rsp_paddr`=0, and nothing is installed, so a repeat request misses again.
- R6: Installs go to slots in round-robin order starting at slot 0 after reset, so the (`ENTRIES`+1)-th install evicts the first one.
- R7: A one-cycle pulse on `flush` invalidates every slot, so every following request misses.
- R8: `req_ready` is low from the cycle after a miss is accepted until the walk response cycle, and a miss response arrives 4 cycles after acceptance when memory answers 2 cycles after `mem_req`.
- R9: After reset, `req_ready`=1, `rsp_valid`=0, `mem_req`=0, and the buffer is empty.
- R10: `mem_req` is a single-cycle pulse per miss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| flush | input | 1 | Invalidate all buffer slots |
| table_base | input | MADDR_W | Base address of the page table |
| req_valid | input | 1 | Translation request |
| req_vaddr | input | VPN_W+OFF_W | Virtual address (page number, offset) |
| req_ready | output | 1 | Walker idle, request accepted |
| rsp_valid | output | 1 | Response pulse |
| rsp_hit | output | 1 | Response came from the buffer |
| rsp_fault | output | 1 | Page not resident |
| rsp_paddr | output | PFN_W+OFF_W | Physical address (0 on fault) |
| mem_req | output | 1 | Page table read request pulse |
| mem_addr | output | MADDR_W | Page table entry address |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | PTE_W | Page table entry |

## Verification
The bench keeps the defaults: 4 slots, an 8-bit page number, a 6-bit offset, a 6-bit frame, 16-bit entries and a 12-bit table address. With only four slots, a handful of requests wraps the round-robin pointer and evicts live translations, so both eviction order and re-misses are observable. The 12-bit table address lets a high base plus a page number wrap around the address space. The modelled table makes every page number congruent to 3 modulo 5 non-resident, which produces faults on demand.

// File: rtl/pxl_pkg.sv
package pxl_pkg;
    typedef enum logic [1:0] {
        WK_IDLE  = 2'd0,
        WK_ISSUE = 2'd1,
        WK_WAIT  = 2'd2
    } walk_state_e;
endpackage

// File: rtl/pxl_rr_victim.sv
module pxl_rr_victim #(
    parameter int ENTRIES = 4,
    localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             advance,
    output logic [IDX_W-1:0] slot
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

    logic [IDX_W-1:0] slot_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            slot_q <= '0;
        end else if (advance) begin
            slot_q <= (slot_q == LAST) ? '0 : slot_q + 1'b1;
        end
    end

    assign slot = slot_q;

    // R6
    rr_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        slot_q <= LAST);
endmodule

// File: rtl/pxl_tlb_cam.sv
module pxl_tlb_cam #(
    parameter int ENTRIES = 4,
    parameter int VPN_W   = 8,
    parameter int PFN_W   = 6,
    localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic [VPN_W-1:0] look_vpn,
    output logic             hit,
    output logic [PFN_W-1:0] hit_pfn,
    input  logic             fill_en,
    input  logic [IDX_W-1:0] fill_slot,
    input  logic [VPN_W-1:0] fill_vpn,
    input  logic [PFN_W-1:0] fill_pfn
);
    logic [ENTRIES-1:0] valid_q;
    logic [VPN_W-1:0]   tag_q [ENTRIES];
    logic [PFN_W-1:0]   pfn_q [ENTRIES];
    logic [ENTRIES-1:0] match;

    genvar gi;
    generate
        for (gi = 0; gi < ENTRIES; gi++) begin : g_cmp
            assign match[gi] = valid_q[gi] && (tag_q[gi] == look_vpn);
        end
    endgenerate

    assign hit = |match;

    always_comb begin
        hit_pfn = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (match[i]) hit_pfn = hit_pfn | pfn_q[i];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_q <= '0;
        end else if (flush) begin
            valid_q <= '0;
        end else if (fill_en) begin
            valid_q[fill_slot] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (fill_en && !flush) begin
            tag_q[fill_slot] <= fill_vpn;
            pfn_q[fill_slot] <= fill_pfn;
        end
    end

    // R2
    single_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(match));

    // R7
    flush_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (valid_q == '0));

    // R4
    fill_marks_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_en && !flush) |=> valid_q[$past(fill_slot)]);
endmodule

// File: rtl/pxl_walk_fsm.sv
module pxl_walk_fsm
    import pxl_pkg::*;
#(
    parameter int VPN_W   = 8,
    parameter int OFF_W   = 6,
    parameter int PFN_W   = 6,
    parameter int PTE_W   = 16,
    parameter int MADDR_W = 12,
    localparam int VA_W = VPN_W + OFF_W,
    localparam int PA_W = PFN_W + OFF_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [MADDR_W-1:0] table_base,
    input  logic               req_valid,
    input  logic [VA_W-1:0]    req_vaddr,
    output logic               req_ready,
    input  logic               tlb_hit,
    input  logic [PFN_W-1:0]   tlb_pfn,
    output logic               rsp_valid,
    output logic               rsp_hit,
    output logic               rsp_fault,
    output logic [PA_W-1:0]    rsp_paddr,
    output logic               mem_req,
    output logic [MADDR_W-1:0] mem_addr,
    input  logic               mem_rsp_valid,
    input  logic [PTE_W-1:0]   mem_rsp_data,
    output logic               fill_en,
    output logic [VPN_W-1:0]   fill_vpn,
    output logic [PFN_W-1:0]   fill_pfn
);
    walk_state_e state_q, state_d;

    logic [VPN_W-1:0]   vpn_q;
    logic [OFF_W-1:0]   off_q;
    logic [MADDR_W-1:0] addr_q;
    logic               rsp_valid_q, rsp_hit_q, rsp_fault_q;
    logic [PA_W-1:0]    rsp_paddr_q;

    logic [VPN_W-1:0] req_vpn;
    logic [OFF_W-1:0] req_off;
    logic             resident;
    logic [PFN_W-1:0] pte_frame;
    logic             accept;
    logic             walk_done;
    logic             unused_pte_bits;

    assign req_vpn   = req_vaddr[VA_W-1:OFF_W];
    assign req_off   = req_vaddr[OFF_W-1:0];
    assign resident  = mem_rsp_data[PTE_W-1];
    assign pte_frame = mem_rsp_data[PFN_W-1:0];
    assign unused_pte_bits = ^mem_rsp_data[PTE_W-2:PFN_W];
    assign accept    = req_valid && (state_q == WK_IDLE);
    assign walk_done = (state_q == WK_WAIT) && mem_rsp_valid;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= WK_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            WK_IDLE:  if (req_valid && !tlb_hit) state_d = WK_ISSUE;
            WK_ISSUE: state_d = WK_WAIT;
            WK_WAIT:  if (mem_rsp_valid) state_d = WK_IDLE;
            default:  state_d = WK_IDLE;
        endcase
    end

    // captured request and response registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vpn_q       <= '0;
            off_q       <= '0;
            addr_q      <= '0;
            rsp_valid_q <= 1'b0;
            rsp_hit_q   <= 1'b0;
            rsp_fault_q <= 1'b0;
            rsp_paddr_q <= '0;
        end else begin
            rsp_valid_q <= 1'b0;
            if (accept) begin
                vpn_q  <= req_vpn;
                off_q  <= req_off;
                addr_q <= table_base + MADDR_W'(req_vpn);
                if (tlb_hit) begin
                    rsp_valid_q <= 1'b1;
                    rsp_hit_q   <= 1'b1;
                    rsp_fault_q <= 1'b0;
                    rsp_paddr_q <= {tlb_pfn, req_off};
                end
            end
            if (walk_done) begin
                rsp_valid_q <= 1'b1;
                rsp_hit_q   <= 1'b0;
                rsp_fault_q <= !resident;
                rsp_paddr_q <= resident ? {pte_frame, off_q} : '0;
            end
        end
    end

    // outputs
    always_comb begin
        req_ready = (state_q == WK_IDLE);
        mem_req   = (state_q == WK_ISSUE);
        mem_addr  = addr_q;
        fill_en   = walk_done && resident;
        fill_vpn  = vpn_q;
        fill_pfn  = pte_frame;
        rsp_valid = rsp_valid_q;
        rsp_hit   = rsp_hit_q;
        rsp_fault = rsp_fault_q;
        rsp_paddr = rsp_paddr_q;
    end

    // R10
    mem_req_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |=> !mem_req);

    // R3
    issue_after_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> $past(req_valid && req_ready && !tlb_hit));

    // R5
    fault_no_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault) |-> ($past(!fill_en) && (rsp_paddr == '0)));
endmodule

// File: rtl/page_xlate_top.sv
module page_xlate_top #(
    parameter int ENTRIES = 4,
    parameter int VPN_W   = 8,
    parameter int OFF_W   = 6,
    parameter int PFN_W   = 6,
    parameter int PTE_W   = 16,
    parameter int MADDR_W = 12,
    localparam int VA_W  = VPN_W + OFF_W,
    localparam int PA_W  = PFN_W + OFF_W,
    localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               flush,
    input  logic [MADDR_W-1:0] table_base,
    input  logic               req_valid,
    input  logic [VA_W-1:0]    req_vaddr,
    output logic               req_ready,
    output logic               rsp_valid,
    output logic               rsp_hit,
    output logic               rsp_fault,
    output logic [PA_W-1:0]    rsp_paddr,
    output logic               mem_req,
    output logic [MADDR_W-1:0] mem_addr,
    input  logic               mem_rsp_valid,
    input  logic [PTE_W-1:0]   mem_rsp_data
);
    logic             tlb_hit;
    logic [PFN_W-1:0] tlb_pfn;
    logic             fill_en;
    logic [VPN_W-1:0] fill_vpn;
    logic [PFN_W-1:0] fill_pfn;
    logic [IDX_W-1:0] victim;

    pxl_tlb_cam #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .PFN_W(PFN_W)) u_cam (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (flush),
        .look_vpn  (req_vaddr[VA_W-1:OFF_W]),
        .hit       (tlb_hit),
        .hit_pfn   (tlb_pfn),
        .fill_en   (fill_en),
        .fill_slot (victim),
        .fill_vpn  (fill_vpn),
        .fill_pfn  (fill_pfn)
    );

    pxl_rr_victim #(.ENTRIES(ENTRIES)) u_rr (
        .clk     (clk),
        .rst_n   (rst_n),
        .advance (fill_en && !flush),
        .slot    (victim)
    );

    pxl_walk_fsm #(
        .VPN_W(VPN_W), .OFF_W(OFF_W), .PFN_W(PFN_W),
        .PTE_W(PTE_W), .MADDR_W(MADDR_W)
    ) u_walk (
        .clk           (clk),
        .rst_n         (rst_n),
        .table_base    (table_base),
        .req_valid     (req_valid),
        .req_vaddr     (req_vaddr),
        .req_ready     (req_ready),
        .tlb_hit       (tlb_hit),
        .tlb_pfn       (tlb_pfn),
        .rsp_valid     (rsp_valid),
        .rsp_hit       (rsp_hit),
        .rsp_fault     (rsp_fault),
        .rsp_paddr     (rsp_paddr),
        .mem_req       (mem_req),
        .mem_addr      (mem_addr),
        .mem_rsp_valid (mem_rsp_valid),
        .mem_rsp_data  (mem_rsp_data),
        .fill_en       (fill_en),
        .fill_vpn      (fill_vpn),
        .fill_pfn      (fill_pfn)
    );

    // R2
    hit_no_mem_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_hit) |-> !mem_req);
endmodule

// File: tb/page_xlate_top_tb.sv
module page_xlate_top_tb;
    localparam int NV = 14;
    localparam int V_VPN [NV] = '{1, 1, 3, 3, 2, 4, 5, 6, 2, 1, 2, 5, 4, 6};
    localparam int V_OFF [NV] = '{5, 9, 0, 63, 1, 2, 3, 4, 10, 11, 12, 13, 14, 15};
    localparam bit V_HIT [NV] = '{0, 1, 0, 0, 0, 0, 0, 0, 1, 0, 0, 1, 0, 1};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        flush = 1'b0;
    logic [11:0] table_base = 12'h100;
    logic        req_valid = 1'b0;
    logic [13:0] req_vaddr = '0;
    logic        req_ready, rsp_valid, rsp_hit, rsp_fault, mem_req;
    logic [11:0] rsp_paddr, mem_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [15:0] mem_rsp_data = '0;

    int checks = 0;
    int fails = 0;
    int mem_cnt = 0;
    logic [11:0] last_addr = '0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    page_xlate_top u_dut (
        .clk(clk), .rst_n(rst_n), .flush(flush), .table_base(table_base),
        .req_valid(req_valid), .req_vaddr(req_vaddr), .req_ready(req_ready),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_fault(rsp_fault),
        .rsp_paddr(rsp_paddr), .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data)
    );

    function automatic bit is_res(int vpn);
        return (vpn % 5) != 3;
    endfunction

    function automatic logic [5:0] frame_of(int vpn);
        return 6'((vpn * 7 + 3) % 64);
    endfunction

    function automatic logic [15:0] pte_of(int vpn);
        if (is_res(vpn)) return {1'b1, 9'd0, frame_of(vpn)};
        return {1'b0, 15'(vpn * 13 + 100)};
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    // page table memory model: answers two cycles after a request
    initial begin
        forever begin
            @(negedge clk);
            if (mem_req) begin
                last_addr = mem_addr;
                mem_cnt++;
                repeat (2) @(negedge clk);
                mem_rsp_data  = pte_of(int'(12'(last_addr - table_base)));
                mem_rsp_valid = 1'b1;
                @(negedge clk);
                mem_rsp_valid = 1'b0;
            end
        end
    end

    task automatic xlate(int vpn, int off, bit exp_hit);
        int c0;
        int cyc;
        bit exp_fault;
        @(negedge clk);
        req_valid = 1'b1;
        req_vaddr = {8'(vpn), 6'(off)};
        c0 = mem_cnt;
        @(negedge clk);
        req_valid = 1'b0;
        cyc = 1;
        chk("R8 ready", 32'(req_ready), 32'(exp_hit));
        while (!rsp_valid && cyc < 40) begin
            @(negedge clk);
            cyc++;
        end
        exp_fault = !exp_hit && !is_res(vpn);
        chk(exp_hit ? "R2 latency" : "R8 latency", 32'(cyc), exp_hit ? 32'd1 : 32'd4);
        chk("R2 hit flag", 32'(rsp_hit), 32'(exp_hit));
        chk("R5 fault flag", 32'(rsp_fault), 32'(exp_fault));
        chk(exp_fault ? "R5 paddr" : "R1 paddr", 32'(rsp_paddr),
            exp_fault ? 32'd0 : 32'({frame_of(vpn), 6'(off)}));
        chk("R3 mem reads", 32'(mem_cnt - c0), exp_hit ? 32'd0 : 32'd1);
        if (!exp_hit) chk("R3 mem addr", 32'(last_addr), 32'(12'(table_base + 12'(vpn))));
        @(negedge clk);
        chk("R10 rsp pulse", 32'(rsp_valid), 32'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R9 reset state
        chk("R9 ready", 32'(req_ready), 32'd1);
        chk("R9 rsp_valid", 32'(rsp_valid), 32'd0);
        chk("R9 mem_req", 32'(mem_req), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 R4 R5 R6 vectors: fill, fault without fill, round-robin evictions
        for (int i = 0; i < NV; i++) xlate(V_VPN[i], V_OFF[i], V_HIT[i]);

        // R7 flush: resident page 6 must miss again after a flush pulse
        @(negedge clk);
        flush = 1'b1;
        @(negedge clk);
        flush = 1'b0;
        xlate(6, 20, 1'b0);
        xlate(6, 21, 1'b1);
        xlate(2, 22, 1'b0);

        // R3 wrap: base plus page number wraps modulo the table address width
        table_base = 12'hFF0;
        xlate(32, 7, 1'b0);
        chk("R3 wrap addr", 32'(last_addr), 32'h010);
        xlate(32, 8, 1'b1);

        // R4 R6 install sequence survives several wraps of the pointer
        for (int k = 40; k < 46; k++) xlate(k, k, (k % 5) == 3 ? 1'b0 : 1'b0);
        xlate(45, 1, 1'b1);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual hung expected done");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end
endmodule